// File: doc/BRIEF.md
# Programmable Reversible Gate Cascade

This block evaluates a chain of programmable reversible gates acting on a four-bit wire bus. Each stage of the chain holds its own configuration word that picks a gate kind (pass-through, controlled-XOR with one control, controlled-XOR with two controls, controlled swap, or a mux/Davio pair), the wires that act as controls and targets, and a small truth table for the control function. The input vector enters stage 0, each stage rewrites only its target wires, and the value leaving the last stage is the result.

In inverse mode the same stages are walked from the last to the first. For the controlled-XOR and controlled-swap kinds this undoes a forward pass, so an output vector can be turned back into the input that produced it. Configuration is loaded one stage at a time through a write port. An optional output register adds one cycle of latency. A stage whose wire choice would make one wire feed two gate terminals is treated as a pass-through, so no fan-out can ever be configured.

Top module: `rc_cascade`

## Requirements
- R1: While rst_ni is low, wires_o is 0 (with the output register present) and every stage is a pass-through. After reset is released and before any configuration write, wires_o equals wires_i.
- R2: Configuration word layout: bits [2:0] kind, [4:3] ctl_a, [6:5] ctl_b, [8:7] tgt_a, [10:9] tgt_b, [14:11] table. Kind 1 (one-control XOR) sets wire tgt_a to wire tgt_a XOR table[x], where x is the value of wire ctl_a. All other wires are unchanged.
- R3: Kind 2 (two-control XOR) sets wire tgt_a to wire tgt_a XOR table[{a,b}], where a is wire ctl_a (the MSB of the index) and b is wire ctl_b. All other wires are unchanged.
- R4: Kind 3 (controlled swap) exchanges wires tgt_a and tgt_b when table[{a,b}] is 1. Otherwise it leaves them unchanged. It always passes the control wires through.
- R5: Kind 4 (mux/Davio) computes f = table[{a,b}], y = wire tgt_a and z = wire tgt_b. It then sets tgt_a to (f ? z : y) and tgt_b to (~f & z) | y. It passes the control wires through. It is not required to be a bijection.
- R6: Kind 0 and the unused kinds 5, 6 and 7 leave all wires unchanged.
- R7: A stage whose wire choice overlaps behaves as a pass-through. Overlap means: for kind 1, ctl_a equals tgt_a; for kind 2, ctl_a, ctl_b and tgt_a are not all distinct; for kinds 3 and 4, ctl_a, ctl_b, tgt_a and tgt_b are not all distinct.
- R8: With inv_i low, the stages apply in the order 0, 1, …, NUM_STAGES-1. With stage words (two-control XOR 0,1→3 AND), (one-control XOR 0→1 copy), (two-control XOR 1,2→3 AND), (one-control XOR 2→1 copy) and inputs (A,B,C,0) on wires 0..3, the output is wire0 = A, wire1 = A^B^C, wire2 = C and wire3 = majority(A,B,C).
- R9: With inv_i high, the stages apply from NUM_STAGES-1 down to 0. For chains built only from kinds 0 to 3, feeding the forward result back in with inv_i high returns the original vector, for all 16 vectors.
- R10: A write with cfg_we_i high loads cfg_data_i into the stage named by cfg_addr_i at the next clock edge. A write to an address of NUM_STAGES or more changes no stage.
- R11: With REG_OUT = 1, wires_o shows the result for the inputs present at the previous rising clock edge. With REG_OUT = 0, the result appears without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | ADDR_W | Stage index for the write |
| cfg_data_i | input | 15 | Stage configuration word |
| inv_i | input | 1 | Run the stages last to first |
| wires_i | input | 4 | Input wire vector |
| wires_o | output | 4 | Output wire vector |

## Verification
The bench builds the cascade with NUM_STAGES = 6 and REG_OUT = 1. With six stages the three-bit address still has two codes (6 and 7) that name no stage, which makes the out-of-range write rule testable. Six stages are also enough to hold the four-stage adder followed by pass-through stages, and a mixed chain that uses every invertible kind for the round-trip test. Because the output register is enabled, the one-cycle latency is checked. For the mux/Davio kind, the bench reports whether the programmed stage is bijective instead of assuming it.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam int unsigned WIRES = 4;

  localparam logic [2:0] KIND_PASS = 3'd0;
  localparam logic [2:0] KIND_CX1  = 3'd1;
  localparam logic [2:0] KIND_CX2  = 3'd2;
  localparam logic [2:0] KIND_SWAP = 3'd3;
  localparam logic [2:0] KIND_MXDV = 3'd4;

  typedef struct packed {
    logic [3:0] tbl;
    logic [1:0] tgt_b;
    logic [1:0] tgt_a;
    logic [1:0] ctl_b;
    logic [1:0] ctl_a;
    logic [2:0] kind;
  } stage_cfg_t;

  localparam int unsigned CFG_W = $bits(stage_cfg_t);

  function automatic logic distinct3(logic [1:0] p, logic [1:0] q, logic [1:0] r);
    return (p != q) && (p != r) && (q != r);
  endfunction

  function automatic logic distinct4(logic [1:0] p, logic [1:0] q,
                                     logic [1:0] r, logic [1:0] s);
    return distinct3(p, q, r) && (s != p) && (s != q) && (s != r);
  endfunction
endpackage

// File: rtl/rc_cfg_regs.sv
module rc_cfg_regs
  import rc_pkg::*;
#(
  parameter int unsigned NUM_STAGES = 8,
  parameter int unsigned ADDR_W     = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  stage_cfg_t                   data_i,
  output stage_cfg_t [NUM_STAGES-1:0]  cfg_o
);
  stage_cfg_t [NUM_STAGES-1:0] cfg_q;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  cfg_q[s] <= '0;
      else if (we_i && (32'(addr_i) == s))          cfg_q[s] <= data_i;
    end
  end

  assign cfg_o = cfg_q;

  assert_cfg_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (32'(addr_i) < NUM_STAGES)) |=> cfg_q[$past(addr_i)] == $past(data_i));

  assert_cfg_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i || (32'(addr_i) >= NUM_STAGES)) |=> $stable(cfg_q));
endmodule

// File: rtl/rc_stage.sv
module rc_stage
  import rc_pkg::*;
(
  input  stage_cfg_t        cfg_i,
  input  logic [WIRES-1:0]  w_i,
  output logic [WIRES-1:0]  w_o
);
  logic a, b, y, z, f1, f2;
  logic [WIRES-1:0] tgt_mask;

  always_comb begin
    a  = w_i[cfg_i.ctl_a];
    b  = w_i[cfg_i.ctl_b];
    y  = w_i[cfg_i.tgt_a];
    z  = w_i[cfg_i.tgt_b];
    f1 = cfg_i.tbl[{1'b0, a}];
    f2 = cfg_i.tbl[{a, b}];
    w_o = w_i;
    case (cfg_i.kind)
      KIND_CX1:
        if (cfg_i.ctl_a != cfg_i.tgt_a) w_o[cfg_i.tgt_a] = y ^ f1;
      KIND_CX2:
        if (distinct3(cfg_i.ctl_a, cfg_i.ctl_b, cfg_i.tgt_a)) w_o[cfg_i.tgt_a] = y ^ f2;
      KIND_SWAP:
        if (distinct4(cfg_i.ctl_a, cfg_i.ctl_b, cfg_i.tgt_a, cfg_i.tgt_b) && f2) begin
          w_o[cfg_i.tgt_a] = z;
          w_o[cfg_i.tgt_b] = y;
        end
      KIND_MXDV:
        if (distinct4(cfg_i.ctl_a, cfg_i.ctl_b, cfg_i.tgt_a, cfg_i.tgt_b)) begin
          w_o[cfg_i.tgt_a] = f2 ? z : y;
          w_o[cfg_i.tgt_b] = (~f2 & z) | y;
        end
      default: ;
    endcase
  end

  // Checks on the settled stage result
  always_comb begin
    tgt_mask = 4'b0001 << cfg_i.tgt_a;
    if (!$isunknown({cfg_i, w_i})) begin
      if (cfg_i.kind inside {KIND_CX1, KIND_CX2, KIND_SWAP, KIND_MXDV})
        assert_ctl_a_pass_R2: assert (w_o[cfg_i.ctl_a] == w_i[cfg_i.ctl_a]);
      if (cfg_i.kind inside {KIND_CX2, KIND_SWAP, KIND_MXDV})
        assert_ctl_b_pass_R3: assert (w_o[cfg_i.ctl_b] == w_i[cfg_i.ctl_b]);
      if (cfg_i.kind inside {KIND_CX1, KIND_CX2})
        assert_single_target_R2: assert (((w_o ^ w_i) & ~tgt_mask) == '0);
      if (cfg_i.kind == KIND_SWAP)
        assert_swap_weight_R4: assert ($countones(w_o) == $countones(w_i));
    end
  end
endmodule

// File: rtl/rc_cascade.sv
module rc_cascade
  import rc_pkg::*;
#(
  parameter int unsigned NUM_STAGES = 8,
  parameter bit          REG_OUT    = 1'b1,
  localparam int unsigned ADDR_W    = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [CFG_W-1:0]  cfg_data_i,
  input  logic              inv_i,
  input  logic [WIRES-1:0]  wires_i,
  output logic [WIRES-1:0]  wires_o
);
  stage_cfg_t [NUM_STAGES-1:0] cfg_all;
  logic [WIRES-1:0] lane [NUM_STAGES+1];

  rc_cfg_regs #(.NUM_STAGES(NUM_STAGES), .ADDR_W(ADDR_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .addr_i (cfg_addr_i),
    .data_i (stage_cfg_t'(cfg_data_i)),
    .cfg_o  (cfg_all)
  );

  assign lane[0] = wires_i;

  // One physical chain; inverse mode re-maps which word each slot uses
  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_slot
    stage_cfg_t slot_cfg;
    assign slot_cfg = inv_i ? cfg_all[NUM_STAGES-1-k] : cfg_all[k];
    rc_stage u_stage (
      .cfg_i (slot_cfg),
      .w_i   (lane[k]),
      .w_o   (lane[k+1])
    );
  end

  if (REG_OUT) begin : g_reg
    logic [WIRES-1:0] out_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) out_q <= '0;
      else         out_q <= lane[NUM_STAGES];
    end
    assign wires_o = out_q;

    assert_out_latency_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> wires_o == $past(lane[NUM_STAGES]));
  end else begin : g_comb
    assign wires_o = lane[NUM_STAGES];
  end
endmodule

// File: tb/rc_cascade_test.sv
module rc_cascade_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 6;
  localparam logic [2:0] K_PASS = 3'd0, K_CX1 = 3'd1, K_CX2 = 3'd2,
                         K_SWAP = 3'd3, K_MXDV = 3'd4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, inv = 1'b0;
  logic [2:0] addr = '0;
  logic [14:0] data = '0;
  logic [3:0] win = '0;
  logic [3:0] wout;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [14:0] shadow [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  rc_cascade #(.NUM_STAGES(N), .REG_OUT(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_data_i(data), .inv_i(inv), .wires_i(win), .wires_o(wout)
  );

  function automatic logic [14:0] mk(logic [2:0] k, int ca, int cb, int ta, int tb, logic [3:0] t);
    return {t, 2'(tb), 2'(ta), 2'(cb), 2'(ca), k};
  endfunction

  // Reference model written from the requirement text
  function automatic logic [3:0] ref_stage(logic [14:0] c, logic [3:0] w);
    logic [3:0] r = w;
    int ca = int'(c[4:3]), cb = int'(c[6:5]), ta = int'(c[8:7]), tb = int'(c[10:9]);
    logic [3:0] t = c[14:11];
    logic f;
    f = t[{w[ca], w[cb]}];
    if (c[2:0] == K_CX1 && ca != ta) r[ta] = w[ta] ^ t[w[ca]];
    else if (c[2:0] == K_CX2 && ca != cb && ca != ta && cb != ta) r[ta] = w[ta] ^ f;
    else if ((c[2:0] == K_SWAP || c[2:0] == K_MXDV) && ca != cb && ca != ta && ca != tb
             && cb != ta && cb != tb && ta != tb) begin
      if (c[2:0] == K_SWAP) begin
        if (f) begin r[ta] = w[tb]; r[tb] = w[ta]; end
      end else begin
        r[ta] = f ? w[tb] : w[ta];
        r[tb] = (~f & w[tb]) | w[ta];
      end
    end
    return r;
  endfunction

  function automatic logic [3:0] ref_run(logic iv, logic [3:0] w);
    logic [3:0] r = w;
    for (int s = 0; s < N; s++) r = ref_stage(shadow[iv ? N-1-s : s], r);
    return r;
  endfunction

  task automatic chk(string req, logic [3:0] got, logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(int a, logic [14:0] d);
    @(negedge clk);
    we = 1'b1; addr = 3'(a); data = d;
    @(negedge clk);
    we = 1'b0;
    if (a < N) shadow[a] = d;
  endtask

  task automatic run(logic iv, logic [3:0] v, output logic [3:0] r);
    @(negedge clk);
    inv = iv; win = v;
    @(negedge clk);
    r = wout;
  endtask

  task automatic clear_all();
    for (int s = 0; s < N; s++) wr(s, '0);
  endtask

  task automatic t_reset();
    logic [3:0] r;
    win = 4'hF;
    #(CLK_PERIOD*3);
    chk("R1 output held low in reset", wout, 4'h0);
    @(negedge clk); rst_n = 1'b1;
    for (int s = 0; s < N; s++) shadow[s] = '0;
    for (int v = 0; v < 16; v += 5) begin
      run(1'b0, 4'(v), r);
      chk("R1 pass-through after reset", r, 4'(v));
    end
  endtask

  task automatic t_cx1();
    logic [3:0] r;
    wr(0, mk(K_CX1, 2, 0, 0, 0, 4'b0010));
    for (int v = 0; v < 16; v++) begin
      run(1'b0, 4'(v), r);
      chk("R2 copy-xor 2->0", r, 4'(v) ^ {3'b0, 1'(v >> 2)});
    end
    wr(0, mk(K_CX1, 3, 0, 1, 0, 4'b0001));
    for (int v = 0; v < 16; v++) begin
      run(1'b0, 4'(v), r);
      chk("R2 inverted-xor 3->1", r, 4'(v) ^ {2'b0, ~1'(v >> 3), 1'b0});
    end
    clear_all();
  endtask

  task automatic t_cx2();
    logic [3:0] r;
    logic [3:0] v4;
    wr(0, mk(K_CX2, 3, 1, 2, 0, 4'b0100));
    for (int v = 0; v < 16; v++) begin
      v4 = 4'(v);
      run(1'b0, v4, r);
      chk("R3 two-control xor index order", r, v4 ^ {1'b0, v4[3] & ~v4[1], 2'b0});
    end
    clear_all();
  endtask

  task automatic t_swap();
    logic [3:0] r, e, v4;
    wr(1, mk(K_SWAP, 0, 1, 2, 3, 4'b0110));
    for (int v = 0; v < 16; v++) begin
      v4 = 4'(v);
      e = (v4[0] ^ v4[1]) ? {v4[2], v4[3], v4[1:0]} : v4;
      run(1'b0, v4, r);
      chk("R4 controlled swap", r, e);
    end
    clear_all();
  endtask

  task automatic t_mxdv();
    logic [3:0] r, e, v4;
    logic f;
    bit seen [16];
    int distinct = 0;
    wr(2, mk(K_MXDV, 0, 1, 2, 3, 4'b1000));
    for (int v = 0; v < 16; v++) begin
      v4 = 4'(v);
      f = v4[0] & v4[1];
      e = {(~f & v4[3]) | v4[2], f ? v4[3] : v4[2], v4[1:0]};
      run(1'b0, v4, r);
      chk("R5 mux/davio formula", r, e);
      if (!seen[r]) begin seen[r] = 1; distinct++; end
    end
    $display("R5 mux/davio stage with AND control: %0d distinct outputs, %s", distinct,
             (distinct == 16) ? "bijective" : "not bijective");
    clear_all();
  endtask

  task automatic t_pass_kinds();
    logic [3:0] r;
    logic [14:0] cfgs [7];
    cfgs[0] = mk(K_CX1, 1, 0, 1, 0, 4'hF);
    cfgs[1] = mk(K_CX2, 0, 2, 2, 0, 4'hF);
    cfgs[2] = mk(K_SWAP, 0, 1, 2, 2, 4'hF);
    cfgs[3] = mk(K_MXDV, 0, 0, 2, 3, 4'hF);
    cfgs[4] = mk(3'd5, 0, 1, 2, 3, 4'hF);
    cfgs[5] = mk(3'd6, 0, 1, 2, 3, 4'hF);
    cfgs[6] = mk(3'd7, 3, 1, 0, 2, 4'hF);
    for (int i = 0; i < 7; i++) begin
      wr(0, cfgs[i]);
      for (int v = 1; v < 16; v += 3) begin
        run(1'b0, 4'(v), r);
        if (i < 4) chk("R7 overlapping wires act as pass-through", r, 4'(v));
        else       chk("R6 unused kind passes wires", r, 4'(v));
      end
    end
    clear_all();
  endtask

  task automatic t_adder();
    logic [3:0] r, v4;
    logic maj;
    wr(0, mk(K_CX2, 0, 1, 3, 0, 4'b1000));
    wr(1, mk(K_CX1, 0, 0, 1, 0, 4'b0010));
    wr(2, mk(K_CX2, 1, 2, 3, 0, 4'b1000));
    wr(3, mk(K_CX1, 2, 0, 1, 0, 4'b0010));
    for (int v = 0; v < 8; v++) begin
      v4 = {1'b0, 3'(v)};
      maj = (v4[0] & v4[1]) | (v4[0] & v4[2]) | (v4[1] & v4[2]);
      run(1'b0, v4, r);
      chk("R8 full adder cascade", r, {maj, v4[2], ^v4[2:0], v4[0]});
    end
    clear_all();
  endtask

  task automatic t_roundtrip();
    logic [3:0] fw, bk;
    wr(0, mk(K_CX1, 0, 0, 1, 0, 4'b0010));
    wr(1, mk(K_CX2, 1, 2, 3, 0, 4'b1000));
    wr(2, mk(K_SWAP, 3, 0, 1, 2, 4'b0110));
    wr(3, mk(K_CX1, 3, 0, 0, 0, 4'b0001));
    wr(4, mk(K_CX2, 2, 0, 3, 0, 4'b1110));
    wr(5, mk(K_SWAP, 1, 2, 0, 3, 4'b1001));
    for (int v = 0; v < 16; v++) begin
      run(1'b0, 4'(v), fw);
      chk("R8 stage order forward", fw, ref_run(1'b0, 4'(v)));
      run(1'b1, fw, bk);
      chk("R9 inverse recovers input", bk, 4'(v));
    end
    inv = 1'b0;
    clear_all();
  endtask

  task automatic t_bad_addr();
    logic [3:0] r;
    wr(6, mk(K_CX1, 0, 0, 1, 0, 4'b0011));
    wr(7, mk(K_CX1, 2, 0, 3, 0, 4'b0011));
    for (int v = 0; v < 16; v += 4) begin
      run(1'b0, 4'(v), r);
      chk("R10 out-of-range write ignored", r, 4'(v));
    end
    wr(5, mk(K_CX1, 0, 0, 1, 0, 4'b0011));
    run(1'b0, 4'h0, r);
    chk("R10 last stage write lands", r, 4'h2);
    clear_all();
  endtask

  task automatic t_latency();
    logic [3:0] r;
    run(1'b0, 4'h3, r);
    @(negedge clk);
    win = 4'hC;
    #1;
    chk("R11 output waits for clock edge", wout, 4'h3);
    @(negedge clk);
    chk("R11 output after one edge", wout, 4'hC);
  endtask

  initial begin
    t_reset();
    t_cx1();
    t_cx2();
    t_swap();
    t_mxdv();
    t_pass_kinds();
    t_adder();
    t_roundtrip();
    t_bad_addr();
    t_latency();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
    end
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired got 1 expected 0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
    end
    $finish;
  end
endmodule